// File: doc/BRIEF.md
# E1 Timeslot-0 Spare and International Bit Inserter

This block sits on the transmit path of an E1 framer, after the frame alignment and CRC4 logic. For every frame it receives the upstream timeslot 0 byte along with the frame's position in the 16-frame multiframe. It returns the same byte, with the international (Si), remote alarm (A) and national (Sa4 to Sa8) bit positions replaced by data from host registers. Each field is replaced only when that field's enable bit is set. The output is combinational, so the block adds no latency to the byte path.

The host can write eight 8-bit data registers and one enable register. On the multiframe boundary, all eight data registers are copied at once into a working shadow. That copy then supplies the bits for all 16 frames, most significant bit first. A message the host does not refresh is therefore sent again unchanged. The boundary also sets a sticky flag, which tells the host when the next message can be loaded. The host clears the flag with a one-cycle pulse.

Top module: `e1sa_tx_insert`

## Requirements
- R1: While reset is asserted and after it is released, all data registers, the enable register, the shadow and `mf_flag` are zero, and `ts0_out` equals `ts0_in`.
- R2: A boundary is a cycle with `ts0_valid` high and `ts0_frame` equal to 0. In a boundary cycle, all eight data registers are copied into the shadow together. The frame-0 byte uses the register values held before that clock edge, so a write in the boundary cycle itself takes effect only from the next multiframe.
- R3: In frame n, each enabled field supplies bit 7-(n>>1) of its shadow register. Bit 7 therefore goes out first, and each register is used up over one multiframe.
- R4: Fields, registers and byte bits map as follows (byte bit 7 is the first bit on the line). Field 0 is register address 0: Si in even frames, byte bit 7. Field 1 is address 1: Si in odd frames, bit 7. Field 2 is address 2: A in odd frames, bit 5. Fields 3 to 7 are addresses 3 to 7: Sa4 to Sa8 in odd frames, bits 4 down to 0.
- R5: The enable register is at address 8, and bit f enables field f. When the bit is clear, that output bit equals the upstream input bit in the same cycle. The enable register takes effect in the cycle after the write. Writes to addresses 9 to 15 have no effect on the output.
- R6: Byte bits 6 to 0 in even frames, and bit 6 in odd frames, always pass through unchanged. With `ts0_valid` low, `ts0_out` equals `ts0_in`.
- R7: A register write during a multiframe leaves the bits of that multiframe unchanged. Registers that are not rewritten are sent again in every later multiframe.
- R8: `mf_flag` goes high in the cycle after a boundary and stays high until the cycle after a `mf_clr` pulse. When a boundary and `mf_clr` fall in the same cycle, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 4 | Host register address (0-7 data, 8 enables) |
| host_wdata | input | 8 | Host write data |
| mf_clr | input | 1 | Write-one pulse that clears `mf_flag` |
| ts0_valid | input | 1 | Timeslot 0 byte present this cycle |
| ts0_frame | input | 4 | Frame number within the multiframe, 0 to 15 |
| ts0_in | input | 8 | Upstream timeslot 0 byte |
| ts0_out | output | 8 | Timeslot 0 byte with the fields inserted |
| mf_flag | output | 1 | Sticky multiframe boundary flag |

## Verification
The bench writes registers in the boundary cycle itself and in the frame just before it. A design that samples on the wrong edge would send the new message one multiframe early, or one multiframe late. Writes made in the middle of a multiframe check that the bits already being sent stay fixed. Without a shadow, the tail of the multiframe would change to the new data. Random enable masks with random upstream bytes test that disabled fields and fixed bit positions pass through. A field mapped to the wrong byte bit, or to the wrong frame parity, would corrupt alignment bits. A `mf_clr` pulse in the same cycle as a boundary checks that setting the flag wins over clearing it, so that a boundary event is never lost.

// File: rtl/e1sa_pkg.sv
package e1sa_pkg;
  localparam int NFLD  = 8;
  localparam int REG_W = 8;
  localparam int FR_W  = 4;
  localparam int TS_W  = 8;

  // Byte bit that field f occupies (bit 7 is first on the line)
  function automatic int fld_pos(input int f);
    if (f <= 1) return 7;
    else if (f == 2) return 5;
    else return 7 - f;
  endfunction

  // Field f lives in odd (non-alignment) frames
  function automatic bit fld_odd(input int f);
    return (f != 0);
  endfunction

  // Register bit sent in a given frame: MSB first, one bit per frame pair
  function automatic logic [2:0] bit_sel(input logic [FR_W-1:0] fr);
    return 3'(REG_W - 1 - int'(fr[FR_W-1:1]));
  endfunction
endpackage

// File: rtl/e1sa_host_regs.sv
module e1sa_host_regs
  import e1sa_pkg::*;
#(
  parameter int N      = NFLD,
  parameter int W      = REG_W,
  parameter int ADDR_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [W-1:0]          wdata,
  output logic [N-1:0][W-1:0]   regs,
  output logic [N-1:0]          ctrl
);
  localparam int CTRL_ADDR = N;

  for (genvar i = 0; i < N; i++) begin : g_reg
    logic hit;
    assign hit = we && (addr == ADDR_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)   regs[i] <= '0;
      else if (hit) regs[i] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                   ctrl <= '0;
    else if (we && addr == ADDR_W'(CTRL_ADDR))    ctrl <= wdata[N-1:0];
  end
endmodule

// File: rtl/e1sa_shadow.sv
module e1sa_shadow
  import e1sa_pkg::*;
#(
  parameter int N = NFLD,
  parameter int W = REG_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [N-1:0][W-1:0] din,
  output logic [N-1:0][W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (!rst_n)    dout <= '0;
    else if (load) dout <= din;
  end
endmodule

// File: rtl/e1sa_overlay.sv
module e1sa_overlay
  import e1sa_pkg::*;
#(
  parameter int N  = NFLD,
  parameter int W  = REG_W,
  parameter int FW = FR_W,
  parameter int BW = TS_W
) (
  input  logic                valid,
  input  logic [FW-1:0]       frame,
  input  logic [BW-1:0]       ts_in,
  input  logic [N-1:0]        ctrl,
  input  logic [N-1:0][W-1:0] src,
  output logic [BW-1:0]       ts_out
);
  logic [2:0]          sel;
  logic [N-1:0][BW-1:0] fmask;
  logic [N-1:0][BW-1:0] fval;
  logic [BW-1:0]        mask;
  logic [BW-1:0]        val;

  assign sel = bit_sel(frame);

  for (genvar f = 0; f < N; f++) begin : g_fld
    localparam int POS = fld_pos(f);
    localparam bit ODD = fld_odd(f);
    logic hit;
    logic bitv;
    assign hit      = valid && ctrl[f] && (frame[0] == ODD);
    assign bitv     = src[f][sel];
    assign fmask[f] = BW'(hit) << POS;
    assign fval[f]  = BW'(hit & bitv) << POS;
  end

  always_comb begin
    mask = '0;
    val  = '0;
    for (int f = 0; f < N; f++) begin
      mask = mask | fmask[f];
      val  = val  | fval[f];
    end
  end

  assign ts_out = (ts_in & ~mask) | val;
endmodule

// File: rtl/e1sa_tx_insert.sv
module e1sa_tx_insert
  import e1sa_pkg::*;
#(
  parameter int N      = NFLD,
  parameter int W      = REG_W,
  parameter int FW     = FR_W,
  parameter int BW     = TS_W,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [W-1:0]      host_wdata,
  input  logic              mf_clr,
  input  logic              ts0_valid,
  input  logic [FW-1:0]     ts0_frame,
  input  logic [BW-1:0]     ts0_in,
  output logic [BW-1:0]     ts0_out,
  output logic              mf_flag
);
  logic [N-1:0][W-1:0] host_q;
  logic [N-1:0][W-1:0] shadow_q;
  logic [N-1:0][W-1:0] src;
  logic [N-1:0]        ctrl_q;
  logic                boundary;

  assign boundary = ts0_valid && (ts0_frame == '0);
  // frame 0 reads the value being captured, later frames read the shadow
  assign src = boundary ? host_q : shadow_q;

  e1sa_host_regs #(.N(N), .W(W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(host_we), .addr(host_addr),
    .wdata(host_wdata), .regs(host_q), .ctrl(ctrl_q)
  );

  e1sa_shadow #(.N(N), .W(W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(boundary), .din(host_q), .dout(shadow_q)
  );

  e1sa_overlay #(.N(N), .W(W), .FW(FW), .BW(BW)) u_ovl (
    .valid(ts0_valid), .frame(ts0_frame), .ts_in(ts0_in),
    .ctrl(ctrl_q), .src(src), .ts_out(ts0_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        mf_flag <= 1'b0;
    else if (boundary) mf_flag <= 1'b1;
    else if (mf_clr)   mf_flag <= 1'b0;
  end
endmodule

// File: rtl/e1sa_tx_insert_chk.sv
module e1sa_tx_insert_chk
  import e1sa_pkg::*;
#(
  parameter int N  = NFLD,
  parameter int W  = REG_W,
  parameter int FW = FR_W,
  parameter int BW = TS_W
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ts0_valid,
  input logic [FW-1:0]       ts0_frame,
  input logic [BW-1:0]       ts0_in,
  input logic [BW-1:0]       ts0_out,
  input logic [N-1:0]        ctrl_q,
  input logic                boundary,
  input logic                mf_clr,
  input logic                mf_flag,
  input logic [N-1:0][W-1:0] shadow_q
);
  AST_FAS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    ts0_valid && !ts0_frame[0] |-> ts0_out[6:0] == ts0_in[6:0]); // R6
  AST_NFAS_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    ts0_valid && ts0_frame[0] |-> ts0_out[6] == ts0_in[6]); // R6
  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !ts0_valid |-> ts0_out == ts0_in); // R6
  AST_DISABLED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q == '0 |-> ts0_out == ts0_in); // R5
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(shadow_q)); // R7
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> mf_flag); // R8
  AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    mf_clr && !boundary |=> !mf_flag); // R8
  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary && !mf_clr |=> $stable(mf_flag)); // R8
endmodule

bind e1sa_tx_insert e1sa_tx_insert_chk #(.N(N), .W(W), .FW(FW), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ts0_valid(ts0_valid), .ts0_frame(ts0_frame),
  .ts0_in(ts0_in), .ts0_out(ts0_out), .ctrl_q(ctrl_q), .boundary(boundary),
  .mf_clr(mf_clr), .mf_flag(mf_flag), .shadow_q(shadow_q)
);

// File: tb/e1sa_tx_insert_tb.sv
module e1sa_tx_insert_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_we = 1'b0;
  logic [3:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic       mf_clr = 1'b0;
  logic       ts0_valid = 1'b0;
  logic [3:0] ts0_frame = '0;
  logic [7:0] ts0_in = '0;
  logic [7:0] ts0_out;
  logic       mf_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0][7:0] m_reg = '0;
  logic [7:0][7:0] m_sh  = '0;
  logic [7:0]      m_ctrl = '0;
  logic            m_flag = 1'b0;
  logic [3:0]      fctr = '0;

  always #2 clk = ~clk;

  e1sa_tx_insert u_dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .mf_clr(mf_clr), .ts0_valid(ts0_valid),
    .ts0_frame(ts0_frame), .ts0_in(ts0_in), .ts0_out(ts0_out), .mf_flag(mf_flag)
  );

  // expected byte, written from the field table of R3/R4
  function automatic logic [7:0] exp_byte(input logic vld, input logic [3:0] fr,
      input logic [7:0] din, input logic [7:0] en, input logic [7:0][7:0] s);
    logic [7:0] o;
    int k;
    o = din;
    k = 7 - (int'(fr) / 2);
    if (vld) begin
      if (fr % 2 == 0) begin
        if (en[0]) o[7] = s[0][k];
      end else begin
        if (en[1]) o[7] = s[1][k];
        if (en[2]) o[5] = s[2][k];
        for (int j = 0; j < 5; j++)
          if (en[3+j]) o[4-j] = s[3+j][k];
      end
    end
    return o;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic step(input logic vld, input logic [3:0] fr, input logic [7:0] din,
      input logic we, input logic [3:0] a, input logic [7:0] wd, input logic clr,
      input string tag);
    logic [7:0] e;
    logic bnd;
    @(negedge clk);
    ts0_valid = vld; ts0_frame = fr; ts0_in = din;
    host_we = we; host_addr = a; host_wdata = wd; mf_clr = clr;
    #1;
    bnd = vld && (fr == 4'd0);
    e = exp_byte(vld, fr, din, m_ctrl, bnd ? m_reg : m_sh);
    chk(ts0_out == e, tag, ts0_out, e);
    chk(mf_flag == m_flag, "R8", {7'd0, mf_flag}, {7'd0, m_flag});
    @(posedge clk);
    if (bnd) m_sh = m_reg;
    if (we) begin
      if (a < 4'd8) m_reg[a[2:0]] = wd;
      else if (a == 4'd8) m_ctrl = wd;
    end
    if (bnd) m_flag = 1'b1;
    else if (clr) m_flag = 1'b0;
  endtask

  task automatic frm(input logic we, input logic [3:0] a, input logic [7:0] wd,
      input logic clr, input string tag);
    step(1'b1, fctr, 8'($urandom), we, a, wd, clr, tag);
    fctr = fctr + 4'd1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      ts0_valid = 1'b1; ts0_frame = 4'd1; ts0_in = 8'($urandom);
      #1;
      chk(ts0_out == ts0_in, "R1", ts0_out, ts0_in);
      chk(mf_flag == 1'b0, "R1", {7'd0, mf_flag}, 8'd0);
    end
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 16; i++) frm(1'b0, 4'd0, 8'd0, 1'b0, "R1");

    // R4/R3: directed patterns, all fields enabled, loaded in frames before boundary
    for (int i = 0; i < 8; i++) frm(1'b1, 4'(i), 8'(8'h11 * (i + 1) ^ 8'hA5), 1'b0, "R4");
    for (int i = 0; i < 7; i++) frm(1'b0, 4'd0, 8'd0, 1'b0, "R4");
    frm(1'b1, 4'd8, 8'hFF, 1'b0, "R4");             // enables written in frame 15
    for (int i = 0; i < 32; i++) frm(1'b0, 4'd0, 8'd0, 1'b0, "R3");

    // R2: write in the boundary cycle goes to the next multiframe
    for (int i = 0; i < 16; i++)
      frm(fctr == 4'd0, 4'd0, 8'h3C, 1'b0, "R2");
    for (int i = 0; i < 16; i++) frm(1'b0, 4'd0, 8'd0, 1'b0, "R2");

    // R7: mid-multiframe writes do not disturb bits in flight
    for (int i = 0; i < 16; i++)
      frm(fctr == 4'd6, 4'(i % 8), 8'(~i), 1'b0, "R7");
    for (int i = 0; i < 16; i++)
      frm(fctr > 4'd2, 4'(fctr % 4'd8), 8'($urandom), 1'b0, "R7");
    for (int i = 0; i < 32; i++) frm(1'b0, 4'd0, 8'd0, 1'b0, "R7");

    // R5: partial enables and ignored addresses
    for (int r = 0; r < 6; r++) begin
      frm(1'b1, 4'd8, 8'($urandom), 1'b0, "R5");
      for (int i = 0; i < 15; i++)
        frm(1'b1, 4'(9 + ($urandom % 7)), 8'($urandom), 1'b0, "R5");
    end

    // R6: idle cycles between bytes
    for (int i = 0; i < 40; i++) begin
      step(1'b0, 4'($urandom), 8'($urandom), 1'b0, 4'd0, 8'd0, 1'b0, "R6");
      frm(1'b0, 4'd0, 8'd0, 1'b0, "R6");
    end

    // R8: clear, then clear together with boundary
    while (fctr != 4'd3) frm(1'b0, 4'd0, 8'd0, 1'b0, "R8");
    frm(1'b0, 4'd0, 8'd0, 1'b1, "R8");
    while (fctr != 4'd0) frm(1'b0, 4'd0, 8'd0, 1'b0, "R8");
    frm(1'b0, 4'd0, 8'd0, 1'b1, "R8");
    for (int i = 0; i < 4; i++) frm(1'b0, 4'd0, 8'd0, 1'b0, "R8");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 6 == 0)
        step(1'b0, 4'($urandom), 8'($urandom), ($urandom % 4) == 0,
             4'($urandom), 8'($urandom), ($urandom % 8) == 0, "R6");
      else
        frm(($urandom % 4) == 0, 4'($urandom % 10), 8'($urandom),
            ($urandom % 8) == 0, "R7");
    end

    done = 1;
    summary();
    $finish;
  end
endmodule